// File: doc/BRIEF.md
# Complex Vector-Matrix Multiplier

This block takes a row of two packed complex numbers and a 2x2 matrix of packed complex numbers and returns the 1x2 complex row they produce. Each complex element carries a signed 16-bit in-phase (I) part and a signed 16-bit quadrature (Q) part. The vector operand is 64 bits wide and the matrix operand is 128 bits wide. Two mode bits travel with each operation. One conjugates the vector before it is used. The other selects between a wide result with 32-bit parts and a narrow result with rounded 16-bit parts.

The datapath is a three-stage pipeline: multiply, accumulate, then round and saturate. A valid/ready handshake wraps it at both ends. A stalled output freezes the whole pipeline, and the input side is not ready during such a stall. When the output is never held back, one operation is accepted every cycle.

Top module: `cvm_matmul`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The result row is C0 = A0*M0 + A1*M2 and C1 = A0*M1 + A1*M3. A complex product (ar + j*ai)(br + j*bi) has real part ar*br - ai*bi and imaginary part ar*bi + ai*br.
- R3: A result becomes valid after the third rising edge, counting the edge that accepts the input. One input is accepted per cycle while `out_ready` stays high.
- R4: When `in_conj` is 1, the Q parts of both vector elements are negated before multiplying. Negating -32768 gives +32768, with no wrap.
- R5: In wide mode (`in_narrow` = 0), each 32-bit output part is the exact sum saturated to the signed 32-bit range.
- R6: In narrow mode (`in_narrow` = 1), each part is computed as (sum + 2^15) arithmetically shifted right by 16, then saturated to signed 16 bits. C0 goes to bits [31:0] and C1 to bits [63:32], and bits [127:64] are zero.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold, `in_ready` is 0, and no operation is lost or duplicated.
- R8: The mode bits are captured with their own operands. Back-to-back operations with different modes each get their own treatment.
- R9: Packing rules:
  - Within a 32-bit complex word, I is in [31:16] and Q is in [15:0].
  - The vector holds A0 in [31:0] and A1 in [63:32].
  - The matrix holds M0, M1, M2 and M3 in ascending 32-bit words from bit 0.
  - The wide result holds C0 in [63:0] and C1 in [127:64], with I in the upper 32 bits of each half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and modes are presented |
| in_ready | output | 1 | Block accepts operands this cycle |
| in_vec | input | 64 | Packed complex row vector A0, A1 |
| in_mat | input | 128 | Packed complex matrix M0..M3 |
| in_conj | input | 1 | Conjugate the vector before use |
| in_narrow | input | 1 | Select rounded 16-bit part output |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Packed complex result row |

## Verification
An operation accepted at a rising edge shows up on `out_data` after the second rising edge following that one, provided `out_ready` stays high. Each cycle a stall happens in between pushes the result back by one more cycle. The bench keeps a three-slot model that shifts under the same stall rule. At every falling edge it compares `out_valid`, `in_ready` and, when valid, `out_data` against the oldest slot. The directed cases wait exactly two more edges after the accepting one before they sample.

// File: rtl/cvm_pkg.sv
package cvm_pkg;
    localparam int E_W   = 16;          // one I or Q part
    localparam int CPX_W = 2 * E_W;     // one packed complex word
    localparam int A_W   = E_W + 1;     // part after optional negation
    localparam int P_W   = 2 * E_W + 2; // product and sum width
    localparam int F_W   = 2 * E_W;     // wide output part
    localparam int NCOL  = 2;           // result columns
    localparam int NPROD = 2 * NCOL;    // complex products per op

    typedef struct packed {
        logic signed [E_W-1:0] re;
        logic signed [E_W-1:0] im;
    } cpx_t;
endpackage

// File: rtl/cvm_cmul.sv
module cvm_cmul #(
    parameter int AW = 17,
    parameter int PW = 34
) (
    input  logic signed [AW-1:0] a_re,
    input  logic signed [AW-1:0] a_im,
    input  logic signed [AW-1:0] b_re,
    input  logic signed [AW-1:0] b_im,
    output logic signed [PW-1:0] p_re,
    output logic signed [PW-1:0] p_im
);
    localparam int MW = 2 * AW;

    logic signed [MW-1:0] m_rr, m_ii, m_ri, m_ir;

    always_comb begin
        m_rr = a_re * b_re;
        m_ii = a_im * b_im;
        m_ri = a_re * b_im;
        m_ir = a_im * b_re;
        p_re = PW'(m_rr) - PW'(m_ii);
        p_im = PW'(m_ri) + PW'(m_ir);
    end
endmodule

// File: rtl/cvm_clip.sv
module cvm_clip #(
    parameter int IN_W  = 34,
    parameter int OUT_W = 32,
    parameter int SHIFT = 0
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam int XW = IN_W + 1;
    localparam logic signed [XW-1:0] MAXV = XW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [XW-1:0] MINV = ~MAXV;

    logic signed [XW-1:0] sh;

    generate
        if (SHIFT > 0) begin : g_rnd
            localparam logic signed [XW-1:0] HALF = XW'(64'sd1 <<< (SHIFT - 1));
            assign sh = (XW'(din) + HALF) >>> SHIFT;
        end else begin : g_pass
            assign sh = XW'(din);
        end
    endgenerate

    always_comb begin
        if (sh > MAXV)      dout = MAXV[OUT_W-1:0];
        else if (sh < MINV) dout = MINV[OUT_W-1:0];
        else                dout = sh[OUT_W-1:0];
    end
endmodule

// File: rtl/cvm_matmul.sv
module cvm_matmul
    import cvm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [NCOL*CPX_W-1:0] in_vec,
    input  logic [NPROD*CPX_W-1:0] in_mat,
    input  logic                  in_conj,
    input  logic                  in_narrow,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [NCOL*2*F_W-1:0] out_data
);
    localparam int OUT_W = NCOL * 2 * F_W;

    typedef struct packed {
        logic                         s1_v;
        logic                         s1_n;
        logic [NPROD-1:0][P_W-1:0]    s1_re;
        logic [NPROD-1:0][P_W-1:0]    s1_im;
        logic                         s2_v;
        logic                         s2_n;
        logic [NCOL-1:0][P_W-1:0]     s2_re;
        logic [NCOL-1:0][P_W-1:0]     s2_im;
        logic                         s3_v;
        logic [OUT_W-1:0]             s3_d;
    } pipe_t;

    pipe_t st_d, st_q;
    logic  stall;

    logic signed [A_W-1:0] va_re [NCOL];
    logic signed [A_W-1:0] va_im [NCOL];
    logic signed [P_W-1:0] pr_re [NPROD];
    logic signed [P_W-1:0] pr_im [NPROD];
    logic signed [F_W-1:0] wf_re [NCOL];
    logic signed [F_W-1:0] wf_im [NCOL];
    logic signed [E_W-1:0] wn_re [NCOL];
    logic signed [E_W-1:0] wn_im [NCOL];

    assign stall     = st_q.s3_v && !out_ready;
    assign in_ready  = !stall;
    assign out_valid = st_q.s3_v;
    assign out_data  = st_q.s3_d;

    // vector unpack with optional conjugation (17-bit so -32768 negates cleanly)
    generate
        for (genvar k = 0; k < NCOL; k++) begin : g_vec
            cpx_t                  w;
            logic signed [A_W-1:0] q_ext;
            assign w         = in_vec[k*CPX_W +: CPX_W];
            assign va_re[k]  = A_W'(w.re);
            assign q_ext     = A_W'(w.im);
            assign va_im[k]  = in_conj ? -q_ext : q_ext;
        end

        // product p pairs vector element p%2 with matrix word 2*(p%2)+p/2
        for (genvar p = 0; p < NPROD; p++) begin : g_prod
            localparam int VI = p % 2;
            localparam int MI = 2 * (p % 2) + p / 2;
            cpx_t mw;
            assign mw = in_mat[MI*CPX_W +: CPX_W];
            cvm_cmul #(.AW(A_W), .PW(P_W)) u_mul (
                .a_re (va_re[VI]),
                .a_im (va_im[VI]),
                .b_re (A_W'(mw.re)),
                .b_im (A_W'(mw.im)),
                .p_re (pr_re[p]),
                .p_im (pr_im[p])
            );
        end

        for (genvar c = 0; c < NCOL; c++) begin : g_clip
            cvm_clip #(.IN_W(P_W), .OUT_W(F_W), .SHIFT(0)) u_wide_re (
                .din ($signed(st_q.s2_re[c])), .dout (wf_re[c]));
            cvm_clip #(.IN_W(P_W), .OUT_W(F_W), .SHIFT(0)) u_wide_im (
                .din ($signed(st_q.s2_im[c])), .dout (wf_im[c]));
            cvm_clip #(.IN_W(P_W), .OUT_W(E_W), .SHIFT(E_W)) u_nar_re (
                .din ($signed(st_q.s2_re[c])), .dout (wn_re[c]));
            cvm_clip #(.IN_W(P_W), .OUT_W(E_W), .SHIFT(E_W)) u_nar_im (
                .din ($signed(st_q.s2_im[c])), .dout (wn_im[c]));
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (!stall) begin
            st_d.s1_v = in_valid;
            st_d.s1_n = in_narrow;
            for (int p = 0; p < NPROD; p++) begin
                st_d.s1_re[p] = pr_re[p];
                st_d.s1_im[p] = pr_im[p];
            end
            st_d.s2_v = st_q.s1_v;
            st_d.s2_n = st_q.s1_n;
            for (int c = 0; c < NCOL; c++) begin
                st_d.s2_re[c] = st_q.s1_re[2*c] + st_q.s1_re[2*c+1];
                st_d.s2_im[c] = st_q.s1_im[2*c] + st_q.s1_im[2*c+1];
            end
            st_d.s3_v = st_q.s2_v;
            st_d.s3_d = '0;
            for (int c = 0; c < NCOL; c++) begin
                if (st_q.s2_n) begin
                    st_d.s3_d[c*CPX_W +: CPX_W] = {wn_re[c], wn_im[c]};
                end else begin
                    st_d.s3_d[c*2*F_W +: 2*F_W] = {wf_re[c], wf_im[c]};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> ($stable(st_q.s2_re) && $stable(st_q.s2_v))); // R7
    AST_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_v && in_ready) |=> st_q.s2_v); // R3
    AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s2_v && in_ready) |=> out_valid); // R3
endmodule

// File: tb/cvm_matmul_test.sv
module cvm_matmul_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [63:0]  in_vec = '0;
    logic [127:0] in_mat = '0;
    logic         in_conj = 1'b0;
    logic         in_narrow = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cvm_matmul uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_vec(in_vec), .in_mat(in_mat), .in_conj(in_conj), .in_narrow(in_narrow),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic longint sat(longint x, int bits);
        longint mx = (64'sd1 <<< (bits - 1)) - 1;
        if (x > mx) return mx;
        if (x < -mx - 1) return -mx - 1;
        return x;
    endfunction

    function automatic logic [127:0] ref_out(logic [63:0] v, logic [127:0] m,
                                             logic cj, logic nr);
        longint ar[2], ai[2], br[4], bi[4], cr[2], ci[2];
        logic [127:0] r = '0;
        for (int k = 0; k < 2; k++) begin
            ar[k] = longint'($signed(v[32*k+16 +: 16]));
            ai[k] = longint'($signed(v[32*k +: 16]));
            if (cj) ai[k] = -ai[k];
        end
        for (int k = 0; k < 4; k++) begin
            br[k] = longint'($signed(m[32*k+16 +: 16]));
            bi[k] = longint'($signed(m[32*k +: 16]));
        end
        for (int c = 0; c < 2; c++) begin
            cr[c] = ar[0]*br[c] - ai[0]*bi[c] + ar[1]*br[c+2] - ai[1]*bi[c+2];
            ci[c] = ar[0]*bi[c] + ai[0]*br[c] + ar[1]*bi[c+2] + ai[1]*br[c+2];
            if (nr) begin
                r[32*c+16 +: 16] = 16'(sat((cr[c] + 32768) >>> 16, 16));
                r[32*c +: 16]    = 16'(sat((ci[c] + 32768) >>> 16, 16));
            end else begin
                r[64*c+32 +: 32] = 32'(sat(cr[c], 32));
                r[64*c +: 32]    = 32'(sat(ci[c], 32));
            end
        end
        return r;
    endfunction

    // cycle model: three slots, shifting under the stall rule
    logic         mv [3];
    logic [127:0] md [3];
    logic [1:0]   mm [3];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin mv[i] <= 1'b0; md[i] <= '0; mm[i] <= '0; end
        end else if (!(mv[2] && !out_ready)) begin
            mv[2] <= mv[1]; md[2] <= md[1]; mm[2] <= mm[1];
            mv[1] <= mv[0]; md[1] <= md[0]; mm[1] <= mm[0];
            mv[0] <= in_valid;
            md[0] <= ref_out(in_vec, in_mat, in_conj, in_narrow);
            mm[0] <= {in_narrow, in_conj};
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_checks++;
            if (in_ready !== !(mv[2] && !out_ready)) begin
                n_fail++;
                $display("FAIL R7 in_ready act=%b exp=%b", in_ready, !(mv[2] && !out_ready));
            end
            n_checks++;
            if (out_valid !== mv[2]) begin
                n_fail++;
                $display("FAIL R3 out_valid act=%b exp=%b", out_valid, mv[2]);
            end
            if (mv[2]) begin
                n_checks++;
                if (out_data !== md[2]) begin
                    n_fail++;
                    if (mm[2][1])      $display("FAIL R6/R8 data act=%h exp=%h", out_data, md[2]);
                    else if (mm[2][0]) $display("FAIL R4/R8 data act=%h exp=%h", out_data, md[2]);
                    else               $display("FAIL R2/R8 data act=%h exp=%h", out_data, md[2]);
                end
            end
        end
    end

    task automatic directed(input logic [63:0] v, input logic [127:0] m, input logic cj,
                            input logic nr, input logic [127:0] exp_d, input string tag);
        @(posedge clk); #1;
        out_ready = 1'b1; in_valid = 1'b1; in_vec = v; in_mat = m; in_conj = cj; in_narrow = nr;
        @(posedge clk); #1;            // accepting edge
        in_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b1 || out_data !== exp_d) begin
            n_fail++;
            $display("FAIL %s directed act=%b/%h exp=1/%h", tag, out_valid, out_data, exp_d);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        n_checks++;                     // R1
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 reset act=%b%b exp=01", out_valid, in_ready);
        end

        // R2 and R9 packing: C0 = 5+16j, C1 = 1+4j
        directed(64'h0003_0000_0001_0002,
                 128'h00010001_00000002_00000001_00050000, 1'b0, 1'b0,
                 128'h00000001_00000004_00000005_00000010, "R2");
        // R5 wide saturation: Q sum 2^32 clips, I sum 0
        directed(64'h8000_8000_8000_8000, {4{32'h8000_8000}}, 1'b0, 1'b0,
                 128'h00000000_7FFFFFFF_00000000_7FFFFFFF, "R5");
        // R6 narrow saturation of the same sums, upper half zero
        directed(64'h8000_8000_8000_8000, {4{32'h8000_8000}}, 1'b0, 1'b1,
                 128'h0000_7FFF_0000_7FFF, "R6");
        // R6 rounding: 32768 -> 1, -32768 -> 0, -32770 -> -1
        directed(64'h0000_0000_0002_0000,
                 128'h00000000_00000000_BFFF0000_4000C000, 1'b0, 1'b1,
                 128'hFFFF0000_00010000, "R6");
        // R4 conjugation of Q=-32768 gives +32768
        directed(64'h0000_0000_0000_8000,
                 128'h00000000_00000000_00010000_00008000, 1'b1, 1'b0,
                 128'h00000000_00008000_40000000_00000000, "R4");

        // R3 full-rate stream with modes changing every op (R8)
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1;
            out_ready = 1'b1; in_valid = 1'b1;
            in_vec = {$urandom, $urandom}; in_mat = {$urandom, $urandom, $urandom, $urandom};
            in_conj = i[0]; in_narrow = i[1];
        end
        // R7 random backpressure, R8 random modes
        for (int i = 0; i < 600; i++) begin
            @(posedge clk); #1;
            in_valid  = ($urandom % 4) != 0;
            out_ready = ($urandom % 3) != 0;
            in_vec = {$urandom, $urandom}; in_mat = {$urandom, $urandom, $urandom, $urandom};
            if (i % 50 == 0) begin in_vec = {4{16'h8000}}; in_mat = {8{16'h8000}}; end
            in_conj = $urandom; in_narrow = $urandom;
        end
        @(posedge clk); #1;
        in_valid = 1'b0; out_ready = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog act=running exp=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule